// File: doc/BRIEF.md
# Serial Converter Command and Readout Port

This block is the device side of a serial link for a two-channel converter. A host frames each transaction with an active-low chip select and sends exactly sixteen bits on the serial data input. The data input is captured on rising serial-clock edges. During the same transaction the block returns the result of the previous conversion, one bit per falling edge, as in SPI mode 0. When chip select is released after a complete frame whose first bit is set, the block stores the new settings and starts a conversion.

The conversion engine is modelled as a counter of divided system-clock cycles. The divide ratio comes from the command word. When the count ends, the signed sample on `sample_in` is formatted and stored. The readout word carries a sign bit, an overrange flag and fourteen data bits. An active-low busy output stays low for the whole conversion. Pulling chip select low during a conversion aborts it and keeps the previous result.

The serial clock, chip select and data input are brought into the system clock through synchronisers. Edges are detected on the synchronised copies, so the serial clock may run at any rate from standstill up to one eighth of the system clock.

Top module: `adc_link_port`

## Requirements
- R1: After reset `busy_n` is 1, `sdo_oe` is 0 and `chan_sel` is 0. The first readout frame returns 16'h0000.
- R2: The first readout bit appears on `sdo` once chip select falls. `sdo` advances one bit on each falling serial-clock edge. `sdi` is captured on each rising serial-clock edge. The first bit received is command bit 15.
- R3: The readout word is sent MSB first. Bit 15 is the sign of the sample (1 = negative). Bit 14 is the overrange flag. Bits 13:0 are the low fourteen bits of the sample in two's complement.
- R4: The overrange flag is 1 exactly when the sample is above 16383 or below -16384. The other bits are still formed as in R3.
- R5: A conversion starts only when chip select rises after exactly 16 received bits with bit 15 equal to 1. Otherwise busy stays high, and the stored channel, divider and result are unchanged.
- R6: Command bits 14:13 select the divider: 00 divides by 1, 01 by 2, and 10 or 11 by 4. `busy_n` stays low for exactly CONV_CYCLES times that ratio system-clock cycles.
- R7: `chan_sel` shows command bit 12 of the most recent frame that started a conversion.
- R8: If chip select falls during a conversion, `busy_n` returns to 1 within a few cycles, no result is stored, and later readouts return the previous result.
- R9: `sdo_oe` is 1 while chip select is low and 0 while it is high.
- R10: When an abort and the end of a conversion land in the same cycle, the abort wins. The word shifted out always equals the word kept in the result register.
- R11: A frame with the serial clock stopped for thousands of cycles in the middle still transfers correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdi | input | 1 | Serial command data, MSB first |
| sample_in | input | RES_W | Signed converter sample, taken when a conversion ends |
| sdo | output | 1 | Serial readout data |
| sdo_oe | output | 1 | Output enable for `sdo` (0 models high impedance) |
| busy_n | output | 1 | Low while a conversion runs |
| chan_sel | output | 1 | Channel selected by the last starting command |

## Verification
Two events can fall in the same cycle: the last divided tick of a conversion and a synchronised chip-select fall that aborts it. The bench starts a conversion and then opens the next frame at a sweep of delays across the end of the conversion, so the cs fall lands before, on and after the completion edge. Each outcome is judged by comparing the word shifted out with a second readout: both must be either the old result or the new one. The sweep must produce both kinds of outcome.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;
   localparam int FRAME_W  = 16;
   localparam int GO_POS   = FRAME_W - 1;
   localparam int DIV_HI   = FRAME_W - 2;
   localparam int DIV_LO   = FRAME_W - 3;
   localparam int CHAN_POS = FRAME_W - 4;

   typedef enum logic [1:0] {
      DIV_BY1     = 2'b00,
      DIV_BY2     = 2'b01,
      DIV_BY4     = 2'b10,
      DIV_BY4_ALT = 2'b11
   } div_code_e;

   typedef struct packed {
      div_code_e div;
      logic      chan;
   } conv_cfg_t;

   // terminal value of the prescaler for a divider code
   function automatic logic [1:0] div_limit(div_code_e c);
      case (c)
         DIV_BY1: return 2'd0;
         DIV_BY2: return 2'd1;
         default: return 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/adc_link_sync.sv
module adc_link_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("adc_link_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("adc_link_sync: WIDTH must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/adc_link_shift.sv
module adc_link_shift #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n_s,
   input  logic               sclk_s,
   input  logic               sdi_s,
   input  logic [FRAME_W-1:0] tx_word,
   output logic               sdo,
   output logic               sdo_oe,
   output logic               cs_fall,
   output logic               frame_end,
   output logic               frame_full,
   output logic [FRAME_W-1:0] rx_word
);
   localparam int CNT_W = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("adc_link_shift: FRAME_W too small");
   end

   logic               cs_q, sclk_q;
   logic               cs_rise, sclk_rise, sclk_fall;
   logic [FRAME_W-1:0] tx_sh;
   logic [CNT_W-1:0]   bit_cnt;

   assign cs_fall   = cs_q & ~cs_n_s;
   assign cs_rise   = ~cs_q & cs_n_s;
   assign sclk_rise = ~sclk_q & sclk_s & ~cs_n_s;
   assign sclk_fall = sclk_q & ~sclk_s & ~cs_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q    <= 1'b1;
         sclk_q  <= 1'b0;
         tx_sh   <= '0;
         rx_word <= '0;
         bit_cnt <= '0;
         sdo_oe  <= 1'b0;
      end else begin
         cs_q   <= cs_n_s;
         sclk_q <= sclk_s;
         if (cs_fall) begin
            tx_sh   <= tx_word;
            rx_word <= '0;
            bit_cnt <= '0;
            sdo_oe  <= 1'b1;
         end else if (cs_rise) begin
            sdo_oe <= 1'b0;
         end else if (!cs_n_s) begin
            if (sclk_rise) begin
               rx_word <= {rx_word[FRAME_W-2:0], sdi_s};
               if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
            end
            if (sclk_fall) tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
         end
      end
   end

   assign sdo        = tx_sh[FRAME_W-1];
   assign frame_end  = cs_rise;
   assign frame_full = (bit_cnt == CNT_FULL);

   // R2: readout bit only moves on a falling serial edge or a frame load
   p_sdo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_fall && !cs_fall) |=> $stable(sdo));
   // R9: output disabled once chip select has been high for two samples
   p_oe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_s && cs_q) |-> !sdo_oe);
endmodule

// File: rtl/adc_link_fmt.sv
module adc_link_fmt #(
   parameter int RES_W  = 16,
   parameter int DATA_W = 14
) (
   input  logic signed [RES_W-1:0]  sample,
   output logic        [DATA_W+1:0] word
);
   if (RES_W < DATA_W + 1) begin : g_bad_width
      $error("adc_link_fmt: RES_W must exceed DATA_W");
   end

   logic over;

   if (RES_W == DATA_W + 1) begin : g_fit
      assign over = 1'b0;
   end else begin : g_wide
      localparam logic signed [RES_W-1:0] HI = RES_W'((1 << DATA_W) - 1);
      localparam logic signed [RES_W-1:0] LO = RES_W'(-(1 << DATA_W));
      assign over = (sample > HI) || (sample < LO);
   end

   assign word = {sample[RES_W-1], over, sample[DATA_W-1:0]};
endmodule

// File: rtl/adc_link_conv.sv
module adc_link_conv
   import adc_link_pkg::*;
#(
   parameter int CONV_CYCLES = 64,
   parameter int WORD_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort_req,
   input  div_code_e         code,
   input  logic [WORD_W-1:0] fmt_word,
   output logic              busy_n,
   output logic [WORD_W-1:0] res_word
);
   localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

   if (CONV_CYCLES < 1) begin : g_bad_len
      $error("adc_link_conv: CONV_CYCLES must be at least 1");
   end

   logic             running;
   logic [1:0]       pre;
   logic [1:0]       lim;
   logic [CNT_W-1:0] cnt;

   assign lim = div_limit(code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running  <= 1'b0;
         pre      <= '0;
         cnt      <= '0;
         res_word <= '0;
      end else if (abort_req && running) begin
         running <= 1'b0;
      end else if (start && !running) begin
         running <= 1'b1;
         pre     <= '0;
         cnt     <= '0;
      end else if (running) begin
         if (pre == lim) begin
            pre <= '0;
            if (cnt == LAST) begin
               running  <= 1'b0;
               res_word <= fmt_word;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            pre <= pre + 1'b1;
         end
      end
   end

   assign busy_n = ~running;

   // R6: prescaler never passes the selected ratio
   p_pre_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pre <= lim);
   // R8: abort ends a running conversion on the next edge
   p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_req && !busy_n) |=> busy_n);
   // R5: an accepted start makes busy low
   p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy_n && !abort_req) |=> !busy_n);
   // R8: result only moves at the end of a conversion
   p_res_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_n && $past(busy_n)) |-> $stable(res_word));
endmodule

// File: rtl/adc_link_port.sv
module adc_link_port
   import adc_link_pkg::*;
#(
   parameter int CONV_CYCLES = 64,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 14,
   parameter int RES_W       = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs_n,
   input  logic                    sclk,
   input  logic                    sdi,
   input  logic signed [RES_W-1:0] sample_in,
   output logic                    sdo,
   output logic                    sdo_oe,
   output logic                    busy_n,
   output logic                    chan_sel
);
   if (FRAME_W != DATA_W + 2) begin : g_bad_frame
      $error("adc_link_port: frame must hold sign, flag and data bits");
   end

   logic               cs_n_s, sclk_s, sdi_s;
   logic               cs_fall, frame_end, frame_full;
   logic               start;
   logic [FRAME_W-1:0] rx_word, res_word, fmt_word;
   conv_cfg_t          cfg;
   logic               unused_rx;

   adc_link_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdi}),
      .q     ({cs_n_s, sclk_s, sdi_s})
   );

   adc_link_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n_s     (cs_n_s),
      .sclk_s     (sclk_s),
      .sdi_s      (sdi_s),
      .tx_word    (res_word),
      .sdo        (sdo),
      .sdo_oe     (sdo_oe),
      .cs_fall    (cs_fall),
      .frame_end  (frame_end),
      .frame_full (frame_full),
      .rx_word    (rx_word)
   );

   adc_link_fmt #(.RES_W(RES_W), .DATA_W(DATA_W)) u_fmt (
      .sample (sample_in),
      .word   (fmt_word)
   );

   assign start = frame_end && frame_full && rx_word[GO_POS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg <= '{div: DIV_BY1, chan: 1'b0};
      else if (start)
         cfg <= '{div: div_code_e'(rx_word[DIV_HI:DIV_LO]), chan: rx_word[CHAN_POS]};
   end

   adc_link_conv #(.CONV_CYCLES(CONV_CYCLES), .WORD_W(FRAME_W)) u_conv (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .abort_req (cs_fall),
      .code      (cfg.div),
      .fmt_word  (fmt_word),
      .busy_n    (busy_n),
      .res_word  (res_word)
   );

   assign chan_sel  = cfg.chan;
   assign unused_rx = ^rx_word[CHAN_POS-1:0];

   // R5: settings move only with an accepted start
   p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(cfg));
endmodule

// File: tb/adc_link_port_tb.sv
module adc_link_port_tb;
   localparam int CONV = 20;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cs_n = 1'b1;
   logic               sclk = 1'b0;
   logic               sdi = 1'b0;
   logic signed [15:0] sample_in = '0;
   logic               sdo, sdo_oe, busy_n, chan_sel;

   int          n_run = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;
   logic [15:0] last_word = 16'h0000;

   always #5 clk = ~clk;

   adc_link_port #(.CONV_CYCLES(CONV)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .sclk      (sclk),
      .sdi       (sdi),
      .sample_in (sample_in),
      .sdo       (sdo),
      .sdo_oe    (sdo_oe),
      .busy_n    (busy_n),
      .chan_sel  (chan_sel)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] fmt(input int v);
      logic [31:0] u;
      u = v;
      return {v < 0, (v > 16383) || (v < -16384), u[13:0]};
   endfunction

   function automatic int ratio(input logic [1:0] c);
      return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 4;
   endfunction

   // one frame, mode 0; pause stretches sclk high after bit pause_at
   task automatic frame(input logic [15:0] cmd, input int nbits, input int pause_at,
                        input int pause, output logic [15:0] rd);
      rd = '0;
      @(negedge clk);
      chk("R9 oe off while cs high", 32'(sdo_oe), 0);
      cs_n = 1'b0;
      repeat (8) @(negedge clk);
      chk("R9 oe on while cs low", 32'(sdo_oe), 1);
      for (int i = 0; i < nbits; i++) begin
         sdi = cmd[15-i];
         repeat (8) @(negedge clk);
         rd[15-i] = sdo;
         sclk = 1'b1;
         repeat (8) @(negedge clk);
         if (i == pause_at) repeat (pause) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (8) @(negedge clk);
      cs_n = 1'b1;
   endtask

   // measures busy low time after a start frame
   task automatic busy_span(output int len);
      int w = 0;
      len = 0;
      while (busy_n && w < 50) begin @(negedge clk); w++; end
      while (!busy_n && len < 1000) begin len++; @(negedge clk); end
   endtask

   task automatic readout(output logic [15:0] rd);
      repeat (10) @(negedge clk);
      frame(16'h0000, 16, -1, 0, rd);
      repeat (10) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] rd;
      chk("R1 busy_n after reset", 32'(busy_n), 1);
      chk("R1 oe after reset", 32'(sdo_oe), 0);
      chk("R1 chan after reset", 32'(chan_sel), 0);
      readout(rd);
      chk("R1 first readout", 32'(rd), 0);
   endtask

   task automatic t_convert(input int v, input logic [1:0] code, input logic ch, input string tag);
      logic [15:0] rd;
      int len;
      sample_in = 16'(v);
      frame({1'b1, code, ch, 12'h5A5}, 16, -1, 0, rd);
      chk({"R2 readout during start ", tag}, 32'(rd), 32'(last_word));
      busy_span(len);
      chk({"R6 busy length ", tag}, 32'(len), 32'(CONV * ratio(code)));
      chk({"R7 chan_sel ", tag}, 32'(chan_sel), 32'(ch));
      readout(rd);
      chk({"R3 R4 word ", tag}, 32'(rd), 32'(fmt(v)));
      last_word = rd;
   endtask

   task automatic t_noop();
      logic [15:0] rd;
      int lows = 0;
      logic ch0;
      ch0 = chan_sel;
      sample_in = 16'sd555;
      frame({1'b0, 2'b11, ~ch0, 12'hFFF}, 16, -1, 0, rd);
      repeat (4 * CONV + 20) begin @(negedge clk); if (!busy_n) lows++; end
      chk("R5 no-op starts nothing", 32'(lows), 0);
      chk("R5 no-op keeps chan", 32'(chan_sel), 32'(ch0));
      readout(rd);
      chk("R5 no-op keeps result", 32'(rd), 32'(last_word));
   endtask

   task automatic t_short();
      logic [15:0] rd;
      int lows = 0;
      logic ch0;
      ch0 = chan_sel;
      sample_in = 16'sd777;
      frame({1'b1, 2'b00, ~ch0, 12'h000}, 15, -1, 0, rd);
      repeat (CONV + 20) begin @(negedge clk); if (!busy_n) lows++; end
      chk("R5 short frame starts nothing", 32'(lows), 0);
      chk("R5 short frame keeps chan", 32'(chan_sel), 32'(ch0));
      readout(rd);
      chk("R5 short frame keeps result", 32'(rd), 32'(last_word));
   endtask

   task automatic t_abort();
      logic [15:0] rd;
      int w = 0;
      sample_in = 16'sd4321;
      frame({1'b1, 2'b10, 1'b0, 12'h000}, 16, -1, 0, rd);
      while (busy_n && w < 50) begin @(negedge clk); w++; end
      chk("R8 conversion began", 32'(busy_n), 0);
      repeat (10) @(negedge clk);
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
      chk("R8 busy released on abort", 32'(busy_n), 1);
      cs_n = 1'b1;
      repeat (4 * CONV + 20) @(negedge clk);
      chk("R8 no late completion", 32'(busy_n), 1);
      readout(rd);
      chk("R8 stale result kept", 32'(rd), 32'(last_word));
   endtask

   task automatic t_static();
      logic [15:0] rd;
      int len;
      sample_in = 16'sd321;
      frame({1'b1, 2'b00, 1'b1, 12'h000}, 16, 7, 3000, rd);
      busy_span(len);
      chk("R11 paused frame starts", 32'(len), 32'(CONV));
      chk("R11 paused frame chan", 32'(chan_sel), 1);
      readout(rd);
      chk("R11 paused frame result", 32'(rd), 32'(fmt(321)));
      last_word = rd;
   endtask

   task automatic t_race();
      logic [15:0] rd, rd1, rd2;
      int n_old = 0;
      int n_new = 0;
      for (int d = 8; d <= 26; d++) begin
         int v = 1000 + d * 37;
         int w = 0;
         sample_in = 16'(v);
         frame({1'b1, 2'b00, 1'b0, 12'h000}, 16, -1, 0, rd);
         while (busy_n && w < 50) begin @(negedge clk); w++; end
         repeat (d) @(negedge clk);
         frame(16'h0000, 16, -1, 0, rd1);
         repeat (10) @(negedge clk);
         readout(rd2);
         chk("R10 word is old or new", 32'((rd1 == last_word) || (rd1 == fmt(v))), 1);
         chk("R10 shifted word matches store", 32'(rd2), 32'(rd1));
         if (rd1 == last_word) n_old++; else n_new++;
         last_word = rd1;
      end
      chk("R10 sweep saw abort", 32'(n_old > 0), 1);
      chk("R10 sweep saw completion", 32'(n_new > 0), 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_convert(1234, 2'b00, 1'b0, "positive");
      t_convert(-1234, 2'b01, 1'b1, "negative");
      t_convert(19000, 2'b10, 1'b0, "over positive");
      t_convert(-19000, 2'b11, 1'b1, "over negative");
      t_convert(16383, 2'b00, 1'b0, "top edge");
      t_convert(-16384, 2'b01, 1'b0, "bottom edge");
      t_convert(16384, 2'b00, 1'b1, "just over");
      t_noop();
      t_short();
      t_abort();
      t_static();
      t_race();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1500000;
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule